// File: doc/BRIEF.md
# Configurable Direct-Mapped Split Cache

This block is an 8 KB direct-mapped cache that sits between a processor's local bus and a simple word-wide memory port. A two-bit mode input picks one of three layouts. In the two unified layouts, all 512 lines of 16 bytes serve a single stream: instruction fetches only, or operand accesses only. In the split layout, the tag and data arrays are cut into two halves of 256 lines each. One half serves instruction fetches and the other serves operand accesses. A read that hits returns its word in the same cycle it is presented.

A read miss in a cached stream fetches the four words of the line into a line-fill buffer. There is one buffer for instructions and one for data. The filled line is then written into the arrays, and the requested word is returned. Stores are write-through. Every store goes to memory, and a store updates the cached word only when its line is already present. An access whose stream the current mode does not cache goes straight to memory as a single word. The memory port is shared, so only one memory access is in flight at any time.

Changing the mode, asserting the clear input, or leaving reset invalidates every line. Invalidation takes one cycle per tag entry, and the block shows busy for that whole time.

Top module: `cfg_cache`

## Requirements
- R1: After reset is released, and after a one-cycle clear_i pulse, busy_o stays high for exactly 512 cycles. While busy_o is high, no response and no memory request is issued. Afterwards every line is invalid, so the next read of a previously cached address misses.
- R2: A read (req_write_i=0) that hits in a cached stream asserts resp_valid_o with resp_hit_o=1 and the cached word in the same cycle as the request. It issues no memory access.
- R3: A read miss in a cached stream issues four memory reads in this order: the line base, base+4, base+8 and base+12, where the line base is the request address with bits [3:0] cleared. It then responds with resp_hit_o=0 and the requested word, and the line hits from then on.
- R4: The mode encoding is mode_i=00 instruction-only, mode_i=01 data-only, and mode_i=1x split. In the two unified modes, address bits [12:4] select the line and bits [31:13] form the tag. Two addresses that differ only in bit 12 therefore occupy different lines, and two that differ only in bit 13 evict each other.
- R5: In split mode, req_instr_i=1 selects the upper half of the lines and req_instr_i=0 the lower half, bits [11:4] select the line within a half, and bits [31:12] form the tag. The same address read as an instruction and as an operand occupies two separate lines. Within one stream, addresses that differ only in bit 12 or only in bit 13 evict each other.
- R6: Every store issues exactly one memory write of req_wdata_i to the word-aligned request address. It responds when memory accepts the write, with resp_hit_o showing whether the line was present. A store hit updates the cached word. A store miss allocates no line.
- R7: In data-only mode an instruction read, and in instruction-only mode an operand read, issues one memory read at the request address with bits [1:0] cleared. It returns the memory word with resp_hit_o=0 and allocates nothing, so repeating the read goes to memory again.
- R8: A change of mode_i starts the same 512-cycle invalidation as R1.
- R9: Once mem_req_o is raised, mem_req_o, mem_addr_o, mem_write_o and mem_wdata_o hold steady until a cycle with mem_ready_i=1. Every memory address is word aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Layout select: 00 instruction-only, 01 data-only, 1x split |
| clear_i | input | 1 | Invalidate all lines |
| busy_o | output | 1 | Invalidation in progress |
| req_valid_i | input | 1 | Request present; held with its fields until resp_valid_o |
| req_instr_i | input | 1 | 1 for instruction fetch, 0 for operand access |
| req_write_i | input | 1 | 1 for store, 0 for read |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data |
| resp_valid_o | output | 1 | Response for the current request |
| resp_hit_o | output | 1 | Line was present in the cache |
| resp_rdata_o | output | 32 | Read data |
| mem_req_o | output | 1 | Memory access request |
| mem_write_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory completes the access this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ready_i |

## Verification
A valid bit left set by a faulty invalidation shows up on the first read after busy_o falls: it answers with resp_hit_o=1 in zero cycles, with no memory read. A wrong index or tag slice in either layout shows up within a few accesses. A pair of addresses that should evict each other both keep hitting, or a pair that should coexist keeps missing. A write-through path that drops the array update, or that allocates on a miss, is exposed by the very next read of that word, through its hit flag, its data, or the count of memory reads it causes.

// File: rtl/cfg_cache_pkg.sv
package cfg_cache_pkg;
  localparam logic [1:0] MODE_INSTR = 2'b00;
  localparam logic [1:0] MODE_DATA  = 2'b01;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_FILL,
    ST_LINE_WR,
    ST_STORE,
    ST_BYPASS
  } cc_state_e;
endpackage

// File: rtl/cc_tag_store.sv
module cc_tag_store #(
  parameter int LINES = 512,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic             rd_valid_o,
  input  logic             we_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (we_i) tag_mem[idx_i] <= wtag_i;
  end

  always_ff @(posedge clk) begin
    if (clr_en_i)  valid_q[clr_idx_i] <= 1'b0;
    else if (we_i) valid_q[idx_i]     <= 1'b1;
  end

  assign rd_tag_o   = tag_mem[idx_i];
  assign rd_valid_o = valid_q[idx_i];
endmodule

// File: rtl/cc_data_store.sv
module cc_data_store #(
  parameter int LINES      = 512,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic                         clk,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [WSEL_W-1:0]            word_i,
  output logic [DATA_W-1:0]            rd_data_o,
  input  logic                         line_we_i,
  input  logic [LINE_WORDS*DATA_W-1:0] line_data_i,
  input  logic                         word_we_i,
  input  logic [DATA_W-1:0]            word_data_i
);
  logic [DATA_W-1:0] bank_rd [LINE_WORDS];

  for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [LINES];
    logic              bank_we;
    logic [DATA_W-1:0] bank_wd;

    assign bank_we = line_we_i | (word_we_i & (word_i == WSEL_W'(b)));
    assign bank_wd = line_we_i ? line_data_i[b*DATA_W +: DATA_W] : word_data_i;

    always_ff @(posedge clk) begin
      if (bank_we) mem[idx_i] <= bank_wd;
    end

    assign bank_rd[b] = mem[idx_i];
  end

  assign rd_data_o = bank_rd[word_i];
endmodule

// File: rtl/cc_fill_buf.sv
module cc_fill_buf #(
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic                         clk,
  input  logic                         we_i,
  input  logic [WSEL_W-1:0]            widx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [LINE_WORDS*DATA_W-1:0] line_o
);
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (we_i && widx_i == WSEL_W'(w)) word_q <= wdata_i;
    end
    assign line_o[w*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/cfg_cache.sv
module cfg_cache
  import cfg_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 512,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              clear_i,
  output logic              busy_o,
  input  logic              req_valid_i,
  input  logic              req_instr_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int IDX_W   = $clog2(LINES);
  localparam int WSEL_W  = $clog2(LINE_WORDS);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int OFF_W   = WSEL_W + BYTE_W;
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W + 1;
  localparam int LINE_BITS = LINE_WORDS * DATA_W;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(LINES - 1);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  cc_state_e         state_q, state_d;
  logic [WSEL_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0]  clr_cnt_q, clr_cnt_d;
  logic              clr_pend_q, clr_pend_d;
  logic [1:0]        mode_q, mode_d;

  logic              split, cacheable, tag_match, hit, clr_start;
  logic [IDX_W-1:0]  line_idx;
  logic [TAG_W-1:0]  req_tag, rd_tag;
  logic              rd_valid;
  logic [WSEL_W-1:0] word_sel;
  logic [DATA_W-1:0] arr_rdata, fb_word;
  logic              tag_we, line_we, word_we, fb_we, clr_en;
  logic [LINE_BITS-1:0] fb_line [2];
  logic [LINE_BITS-1:0] fb_sel_line;
  logic              unused_low;

  assign unused_low = ^req_addr_i[BYTE_W-1:0];

  // Address decode: layout depends on the active mode
  assign split     = mode_q[1];
  assign cacheable = split | ((mode_q == MODE_INSTR) & req_instr_i)
                           | ((mode_q == MODE_DATA) & ~req_instr_i);
  assign line_idx  = split ? {req_instr_i, req_addr_i[OFF_W+IDX_W-2:OFF_W]}
                           : req_addr_i[OFF_W+IDX_W-1:OFF_W];
  assign req_tag   = req_addr_i[ADDR_W-1:ADDR_W-TAG_W];
  assign word_sel  = req_addr_i[OFF_W-1:BYTE_W];
  assign tag_match = split ? (rd_tag == req_tag)
                           : (rd_tag[TAG_W-1:1] == req_tag[TAG_W-1:1]);
  assign hit       = rd_valid & tag_match & cacheable;
  assign clr_start = clear_i | clr_pend_q | (mode_i != mode_q);

  cc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .idx_i      (line_idx),
    .rd_tag_o   (rd_tag),
    .rd_valid_o (rd_valid),
    .we_i       (tag_we),
    .wtag_i     (req_tag),
    .clr_en_i   (clr_en),
    .clr_idx_i  (clr_cnt_q)
  );

  for (genvar s = 0; s < 2; s++) begin : g_fill
    cc_fill_buf #(.LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .we_i    (fb_we & (req_instr_i == 1'(s))),
      .widx_i  (beat_q),
      .wdata_i (mem_rdata_i),
      .line_o  (fb_line[s])
    );
  end

  assign fb_sel_line = fb_line[req_instr_i];

  always_comb begin
    fb_word = '0;
    for (int w = 0; w < LINE_WORDS; w++) begin
      if (word_sel == WSEL_W'(w)) fb_word = fb_sel_line[w*DATA_W +: DATA_W];
    end
  end

  cc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .idx_i       (line_idx),
    .word_i      (word_sel),
    .rd_data_o   (arr_rdata),
    .line_we_i   (line_we),
    .line_data_i (fb_sel_line),
    .word_we_i   (word_we),
    .word_data_i (req_wdata_i)
  );

  // Next-state and output logic
  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    clr_cnt_d    = clr_cnt_q;
    clr_pend_d   = clr_pend_q | clear_i;
    mode_d       = mode_q;
    busy_o       = 1'b0;
    resp_valid_o = 1'b0;
    resp_hit_o   = 1'b0;
    resp_rdata_o = '0;
    mem_req_o    = 1'b0;
    mem_write_o  = 1'b0;
    mem_addr_o   = '0;
    mem_wdata_o  = '0;
    tag_we       = 1'b0;
    line_we      = 1'b0;
    word_we      = 1'b0;
    fb_we        = 1'b0;
    clr_en       = 1'b0;
    unique case (state_q)
      ST_CLEAR: begin
        busy_o     = 1'b1;
        clr_en     = 1'b1;
        mode_d     = mode_i;
        clr_pend_d = 1'b0;
        if (clr_cnt_q == LAST_IDX) begin
          state_d   = ST_IDLE;
          clr_cnt_d = '0;
        end else begin
          clr_cnt_d = clr_cnt_q + IDX_W'(1);
        end
      end
      ST_IDLE: begin
        if (clr_start) begin
          state_d    = ST_CLEAR;
          clr_pend_d = 1'b0;
        end else if (req_valid_i) begin
          if (req_write_i) begin
            state_d = ST_STORE;
          end else if (!cacheable) begin
            state_d = ST_BYPASS;
          end else if (hit) begin
            resp_valid_o = 1'b1;
            resp_hit_o   = 1'b1;
            resp_rdata_o = arr_rdata;
          end else begin
            state_d = ST_FILL;
            beat_d  = '0;
          end
        end
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {req_addr_i[ADDR_W-1:OFF_W], beat_q, {BYTE_W{1'b0}}};
        if (mem_ready_i) begin
          fb_we = 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_LINE_WR;
          else                     beat_d  = beat_q + WSEL_W'(1);
        end
      end
      ST_LINE_WR: begin
        line_we      = 1'b1;
        tag_we       = 1'b1;
        resp_valid_o = 1'b1;
        resp_rdata_o = fb_word;
        state_d      = ST_IDLE;
      end
      ST_STORE: begin
        mem_req_o   = 1'b1;
        mem_write_o = 1'b1;
        mem_addr_o  = {req_addr_i[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        mem_wdata_o = req_wdata_i;
        if (mem_ready_i) begin
          resp_valid_o = 1'b1;
          resp_hit_o   = hit;
          word_we      = hit;
          state_d      = ST_IDLE;
        end
      end
      ST_BYPASS: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {req_addr_i[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        if (mem_ready_i) begin
          resp_valid_o = 1'b1;
          resp_rdata_o = mem_rdata_i;
          state_d      = ST_IDLE;
        end
      end
      default: state_d = ST_CLEAR;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_CLEAR;
      beat_q     <= '0;
      clr_cnt_q  <= '0;
      clr_pend_q <= 1'b0;
      mode_q     <= MODE_INSTR;
    end else begin
      state_q    <= state_d;
      beat_q     <= beat_d;
      clr_cnt_q  <= clr_cnt_d;
      clr_pend_q <= clr_pend_d;
      mode_q     <= mode_d;
    end
  end
endmodule

// File: rtl/cfg_cache_chk.sv
module cfg_cache_chk #(
  parameter int LINES  = 512,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              req_write_i,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic              mem_req_o,
  input logic              mem_write_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ready_i
);
  logic [31:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run_q <= '0;
    else if (busy_o) busy_run_q <= busy_run_q + 32'd1;
    else             busy_run_q <= '0;
  end

  assert_busy_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!resp_valid_o && !mem_req_o));

  assert_clear_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run_q == 32'(LINES)));

  assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_hit_o && !req_write_i) |-> !mem_req_o);

  assert_store_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && req_write_i) |-> (mem_req_o && mem_write_o && mem_ready_i));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_write_o) && $stable(mem_wdata_o)));

  assert_word_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
endmodule

bind cfg_cache cfg_cache_chk #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .req_write_i  (req_write_i),
  .resp_valid_o (resp_valid_o),
  .resp_hit_o   (resp_hit_o),
  .mem_req_o    (mem_req_o),
  .mem_write_o  (mem_write_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ready_i  (mem_ready_i)
);

// File: tb/cfg_cache_tb.sv
`timescale 1ns/1ps
module cfg_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        clear_i;
  logic        busy_o;
  logic        req_valid_i, req_instr_i, req_write_i;
  logic [31:0] req_addr_i, req_wdata_i;
  logic        resp_valid_o, resp_hit_o;
  logic [31:0] resp_rdata_o;
  logic        mem_req_o, mem_write_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ready_i;
  logic [31:0] mem_rdata_i;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] store_m [logic [31:0]];
  logic [31:0] log_addr [$];
  logic [31:0] log_data [$];
  bit          log_wr [$];

  always #2.5 clk = ~clk;

  cfg_cache u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clear_i(clear_i), .busy_o(busy_o),
    .req_valid_i(req_valid_i), .req_instr_i(req_instr_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .resp_rdata_o(resp_rdata_o),
    .mem_req_o(mem_req_o), .mem_write_o(mem_write_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    if (store_m.exists(a)) return store_m[a];
    return pat(a);
  endfunction

  // Memory model: grants every other cycle, logs each access
  initial begin
    mem_ready_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (mem_ready_i) begin
        mem_ready_i = 1'b0;
      end else if (rst_n && mem_req_o) begin
        log_addr.push_back(mem_addr_o);
        log_data.push_back(mem_wdata_o);
        log_wr.push_back(mem_write_o);
        if (mem_write_o) begin
          store_m[mem_addr_o] = mem_wdata_o;
          mem_rdata_i = '0;
        end else begin
          mem_rdata_i = mem_val(mem_addr_o);
        end
        mem_ready_i = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit instr, input bit wr, input logic [31:0] addr,
                        input logic [31:0] wdata, output logic [31:0] rdata,
                        output bit hit, output int lat);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_instr_i = instr;
    req_write_i = wr;
    req_addr_i  = addr;
    req_wdata_i = wdata;
    lat = 0;
    #1;
    while (!resp_valid_o && lat < 2000) begin
      @(negedge clk);
      #1;
      lat++;
    end
    rdata = resp_rdata_o;
    hit   = resp_hit_o;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy_o && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Read and check data and hit flag; returns memory accesses it caused
  task automatic rd(input string req, input bit instr, input logic [31:0] addr,
                    input bit exp_hit, output int n_mem);
    logic [31:0] d;
    bit h;
    int lat;
    int base;
    base = log_addr.size();
    access(instr, 1'b0, addr, '0, d, h, lat);
    n_mem = log_addr.size() - base;
    chk(h == exp_hit, req, $sformatf("hit flag @%08h", addr), 32'(h), 32'(exp_hit));
    chk(d == mem_val({addr[31:2], 2'b00}), req, $sformatf("read data @%08h", addr),
        d, mem_val({addr[31:2], 2'b00}));
    if (exp_hit) chk(lat == 0, req, "hit latency", lat, 0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    int n;
    @(negedge clk);
    mode_i = m;
    @(negedge clk);
    wait_busy(n);
    chk(n == 512, "R8", "invalidation length after mode change", n, 512);
  endtask

  task automatic t_reset_r1();
    int n;
    chk(busy_o == 1'b1, "R1", "busy at reset release", 32'(busy_o), 1);
    chk(mem_req_o == 1'b0, "R1", "no memory request at reset", 32'(mem_req_o), 0);
    wait_busy(n);
    chk(n == 512, "R1", "invalidation length after reset", n, 512);
  endtask

  task automatic t_fill_r3();
    int n, base;
    base = log_addr.size();
    rd("R3", 1'b0, 32'h0000_1234, 1'b0, n);
    chk(n == 4, "R3", "fill beat count", n, 4);
    for (int k = 0; k < 4; k++) begin
      if (base + k < log_addr.size()) begin
        chk(log_addr[base+k] == 32'h0000_1230 + 32'(4*k) && !log_wr[base+k], "R3",
            $sformatf("fill beat %0d address", k), log_addr[base+k], 32'h0000_1230 + 32'(4*k));
      end
    end
  endtask

  task automatic t_hit_r2();
    int n;
    rd("R2", 1'b0, 32'h0000_1238, 1'b1, n);
    chk(n == 0, "R2", "memory accesses on hit", n, 0);
    rd("R2", 1'b0, 32'h0000_123C, 1'b1, n);
    chk(n == 0, "R2", "memory accesses on second hit", n, 0);
  endtask

  task automatic t_split_r5();
    int n;
    rd("R5", 1'b1, 32'h0000_1234, 1'b0, n);
    chk(n == 4, "R5", "instruction half fills separately", n, 4);
    rd("R5", 1'b0, 32'h0000_1234, 1'b1, n);
    rd("R5", 1'b0, 32'h0000_0234, 1'b0, n);
    rd("R5", 1'b0, 32'h0000_1234, 1'b0, n);
    chk(n == 4, "R5", "bit 12 evicts in split mode", n, 4);
    rd("R5", 1'b1, 32'h0000_1234, 1'b1, n);
    rd("R5", 1'b0, 32'h0000_3234, 1'b0, n);
    rd("R5", 1'b0, 32'h0000_1234, 1'b0, n);
    chk(n == 4, "R5", "bit 13 evicts in split mode", n, 4);
  endtask

  task automatic t_store_r6();
    logic [31:0] d;
    bit h;
    int lat, base, n;
    base = log_addr.size();
    access(1'b0, 1'b1, 32'h0000_1238, 32'hCAFE_0001, d, h, lat);
    chk(log_addr.size() - base == 1, "R6", "store hit memory writes", log_addr.size() - base, 1);
    chk(log_wr[base] && log_addr[base] == 32'h0000_1238 && log_data[base] == 32'hCAFE_0001,
        "R6", "store hit write data", log_data[base], 32'hCAFE_0001);
    chk(h == 1'b1, "R6", "store hit flag", 32'(h), 1);
    rd("R6", 1'b0, 32'h0000_1238, 1'b1, n);
    base = log_addr.size();
    access(1'b0, 1'b1, 32'h0000_567A, 32'hBEEF_0002, d, h, lat);
    chk(h == 1'b0, "R6", "store miss flag", 32'(h), 0);
    chk(log_wr[base] && log_addr[base] == 32'h0000_5678, "R6", "store miss address",
        log_addr[base], 32'h0000_5678);
    rd("R6", 1'b0, 32'h0000_5678, 1'b0, n);
    chk(n == 4, "R6", "store miss did not allocate", n, 4);
  endtask

  task automatic t_unified_r4();
    int n;
    set_mode(2'b01);
    rd("R8", 1'b0, 32'h0000_1234, 1'b0, n);
    rd("R4", 1'b0, 32'h0000_0234, 1'b0, n);
    rd("R4", 1'b0, 32'h0000_1234, 1'b1, n);
    rd("R4", 1'b0, 32'h0000_3234, 1'b0, n);
    rd("R4", 1'b0, 32'h0000_1234, 1'b0, n);
    chk(n == 4, "R4", "bit 13 evicts in unified mode", n, 4);
  endtask

  task automatic t_bypass_r7();
    int n, base;
    base = log_addr.size();
    rd("R7", 1'b1, 32'h0000_4446, 1'b0, n);
    chk(n == 1 && log_addr[base] == 32'h0000_4444, "R7", "instruction bypass single read",
        log_addr[base], 32'h0000_4444);
    rd("R7", 1'b1, 32'h0000_4444, 1'b0, n);
    chk(n == 1, "R7", "bypass did not allocate", n, 1);
    set_mode(2'b00);
    rd("R7", 1'b0, 32'h0000_8888, 1'b0, n);
    chk(n == 1, "R7", "operand bypass in instruction-only mode", n, 1);
    rd("R7", 1'b1, 32'h0000_1234, 1'b0, n);
    rd("R7", 1'b1, 32'h0000_1234, 1'b1, n);
  endtask

  task automatic t_clear_r1();
    int n;
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    wait_busy(n);
    chk(n == 512, "R1", "invalidation length after clear", n, 512);
    rd("R1", 1'b1, 32'h0000_1234, 1'b0, n);
    chk(n == 4, "R1", "line refetched after clear", n, 4);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode_i = 2'b10;
    clear_i = 1'b0;
    req_valid_i = 1'b0;
    req_instr_i = 1'b0;
    req_write_i = 1'b0;
    req_addr_i = '0;
    req_wdata_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_fill_r3();
    t_hit_r2();
    t_split_r5();
    t_store_r6();
    t_unified_r4();
    t_bypass_r7();
    t_clear_r1();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule